// File: doc/BRIEF.md
# Stack and control-flow sequencer

This block is the execute-stage controller for stack and control-transfer instructions in a small 8-bit core whose code, data and stack share one 256-byte memory. The decode stage presents an opcode together with the instruction's own address, its absolute target operand, the value of the register it names and the current zero flag. The block owns the stack pointer, drives the shared memory port for stack traffic, sends PC redirects to the fetch unit and returns popped bytes to the register file.

Pushes, calls, jumps and halt finish in one cycle. Pops and returns wait on a synchronous memory read and keep the block busy for two extra cycles, during which new issues are ignored. The stack grows downward, wraps silently through the 8-bit address space, and a call saves the address of the instruction after itself. Once halt executes the block accepts nothing more until reset.

Top module: `ctl_stack_seq`

## Requirements
- R1: After reset sp_o is 0xFF, and halted_o, busy_o, mem_req_o, mem_we_o, redirect_o and wb_valid_o are all 0.
- R2: An accepted push (opcode 0x07) sets sp_o to SP-1 modulo 256 and, in the cycle after the accepting edge, issues a one-cycle write of reg_val_i to address SP-1, so SP 0x00 wraps to 0xFF.
- R3: An accepted pop (opcode 0x08) issues a read of address SP and sets sp_o to SP+1 modulo 256 in the cycle after acceptance; busy_o is 1 for the two cycles after the accepting edge, and in the third cycle wb_valid_o pulses with wb_data_o equal to the byte stored at that address.
- R4: An accepted call, absolute (0x20, target from target_i) or register-indirect (0x26, target from reg_val_i), writes pc_i+2 modulo 256 to address SP-1, sets SP to SP-1 and pulses redirect_o with redirect_pc_o equal to the target, all in the cycle after acceptance.
- R5: An accepted return (0x21) reads address SP, sets SP to SP+1, holds busy_o for two cycles and in the third cycle pulses redirect_o with redirect_pc_o equal to the byte read, without pulsing wb_valid_o.
- R6: An accepted jump, absolute (0x16, target_i) or register-indirect (0x25, reg_val_i), pulses redirect_o with that target in the next cycle and touches neither memory nor SP.
- R7: Opcode 0x17 redirects to target_i only when zero_i is 1 and opcode 0x18 only when zero_i is 0; when not taken neither produces any output activity.
- R8: Opcode 0x00 sets halted_o, which then stays 1 until reset; while halted no issue is accepted, so no memory request, redirect or SP change occurs.
- R9: Any other opcode produces no memory request, redirect, write-back or SP change.
- R10: An issue presented while busy_o is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction presented this cycle |
| opcode_i | input | 8 | Opcode of the presented instruction |
| pc_i | input | W | Address of the presented instruction |
| target_i | input | W | Absolute target operand |
| reg_val_i | input | W | Value of the register named by the instruction |
| zero_i | input | 1 | Current zero flag |
| busy_o | output | 1 | Read in progress; issues are ignored |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | W | Memory address |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid the cycle after a read request |
| sp_o | output | W | Stack pointer |
| redirect_o | output | 1 | PC redirect pulse to fetch |
| redirect_pc_o | output | W | Redirect target |
| wb_valid_o | output | 1 | Popped byte valid for register write-back |
| wb_data_o | output | W | Popped byte |
| halted_o | output | 1 | Halt executed |

## Verification
The bench builds the block with its default width of 8, so the whole 256-entry address space and every stack pointer value are within reach. Full sweeps of 256 pushes and pops walk SP around the wrap point at 0x00/0xFF in both directions, every call address from 0x00 to 0xFF exercises the wrapping return address, and all 256 opcodes are swept to prove that those outside the handled set do nothing.

// File: rtl/scf_pkg.sv
package scf_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_HALT  = 8'h00;
  localparam logic [OPC_W-1:0] OP_PUSH  = 8'h07;
  localparam logic [OPC_W-1:0] OP_POP   = 8'h08;
  localparam logic [OPC_W-1:0] OP_JMP   = 8'h16;
  localparam logic [OPC_W-1:0] OP_JZ    = 8'h17;
  localparam logic [OPC_W-1:0] OP_JNZ   = 8'h18;
  localparam logic [OPC_W-1:0] OP_CALL  = 8'h20;
  localparam logic [OPC_W-1:0] OP_RET   = 8'h21;
  localparam logic [OPC_W-1:0] OP_JMPR  = 8'h25;
  localparam logic [OPC_W-1:0] OP_CALLR = 8'h26;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_PUSH,
    CLS_POP,
    CLS_CALL,
    CLS_RET,
    CLS_JMP,
    CLS_HALT
  } op_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/scf_decode.sv
module scf_decode
  import scf_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             zero_i,
  output op_cls_e          cls_o,
  output logic             use_reg_o
);
  always_comb begin
    cls_o     = CLS_NONE;
    use_reg_o = 1'b0;
    case (opcode_i)
      OP_PUSH:  cls_o = CLS_PUSH;
      OP_POP:   cls_o = CLS_POP;
      OP_CALL:  cls_o = CLS_CALL;
      OP_CALLR: begin cls_o = CLS_CALL; use_reg_o = 1'b1; end
      OP_RET:   cls_o = CLS_RET;
      OP_JMP:   cls_o = CLS_JMP;
      OP_JMPR:  begin cls_o = CLS_JMP; use_reg_o = 1'b1; end
      // conditional forms collapse to jump or nothing here
      OP_JZ:    cls_o = zero_i ? CLS_JMP : CLS_NONE;
      OP_JNZ:   cls_o = zero_i ? CLS_NONE : CLS_JMP;
      OP_HALT:  cls_o = CLS_HALT;
      default:  cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/scf_stack_ptr.sv
module scf_stack_ptr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dec_i,
  input  logic         inc_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] sp_dn_o
);
  localparam logic [W-1:0] SP_INIT = {W{1'b1}};

  logic [W-1:0] sp_q;

  assign sp_dn_o = sp_q - W'(1);
  assign sp_o    = sp_q;

  // wraps modulo 2**W, no fault
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_INIT;
    else if (dec_i) sp_q <= sp_dn_o;
    else if (inc_i) sp_q <= sp_q + W'(1);
  end
endmodule

// File: rtl/scf_fsm.sv
module scf_fsm
  import scf_pkg::*;
#(
  parameter int W        = 8,
  parameter int CALL_LEN = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         issue_i,
  input  op_cls_e      cls_i,
  input  logic         use_reg_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] reg_val_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] sp_dn_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         sp_dec_o,
  output logic         sp_inc_o,
  output logic         busy_o,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         redirect_o,
  output logic [W-1:0] redirect_pc_o,
  output logic         wb_valid_o,
  output logic [W-1:0] wb_data_o,
  output logic         halted_o
);
  localparam logic [W-1:0] RET_OFS = W'(CALL_LEN);

  seq_st_e      st_q;
  logic         halted_q, pend_ret_q;
  logic         accept;
  op_cls_e      acc_cls;
  logic [W-1:0] dest;

  assign accept   = issue_i && (st_q == ST_IDLE) && !halted_q;
  assign acc_cls  = accept ? cls_i : CLS_NONE;
  assign dest     = use_reg_i ? reg_val_i : target_i;
  assign sp_dec_o = (acc_cls == CLS_PUSH) || (acc_cls == CLS_CALL);
  assign sp_inc_o = (acc_cls == CLS_POP)  || (acc_cls == CLS_RET);
  assign busy_o   = (st_q != ST_IDLE);
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      halted_q      <= 1'b0;
      pend_ret_q    <= 1'b0;
      mem_req_o     <= 1'b0;
      mem_we_o      <= 1'b0;
      mem_addr_o    <= '0;
      mem_wdata_o   <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      wb_valid_o    <= 1'b0;
      wb_data_o     <= '0;
    end else begin
      mem_req_o  <= 1'b0;
      mem_we_o   <= 1'b0;
      redirect_o <= 1'b0;
      wb_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          case (acc_cls)
            CLS_PUSH: begin
              mem_req_o   <= 1'b1;
              mem_we_o    <= 1'b1;
              mem_addr_o  <= sp_dn_i;
              mem_wdata_o <= reg_val_i;
            end
            CLS_CALL: begin
              mem_req_o     <= 1'b1;
              mem_we_o      <= 1'b1;
              mem_addr_o    <= sp_dn_i;
              mem_wdata_o   <= pc_i + RET_OFS;
              redirect_o    <= 1'b1;
              redirect_pc_o <= dest;
            end
            CLS_POP, CLS_RET: begin
              mem_req_o  <= 1'b1;
              mem_addr_o <= sp_i;
              pend_ret_q <= (acc_cls == CLS_RET);
              st_q       <= ST_RD;
            end
            CLS_JMP: begin
              redirect_o    <= 1'b1;
              redirect_pc_o <= dest;
            end
            CLS_HALT: halted_q <= 1'b1;
            default: ;
          endcase
        end
        ST_RD: st_q <= ST_WAIT;
        ST_WAIT: begin
          st_q <= ST_IDLE;
          if (pend_ret_q) begin
            redirect_o    <= 1'b1;
            redirect_pc_o <= mem_rdata_i;
          end else begin
            wb_valid_o <= 1'b1;
            wb_data_o  <= mem_rdata_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctl_stack_seq.sv
module ctl_stack_seq
  import scf_pkg::*;
#(
  parameter int W        = 8,
  parameter int CALL_LEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [W-1:0]     pc_i,
  input  logic [W-1:0]     target_i,
  input  logic [W-1:0]     reg_val_i,
  input  logic             zero_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [W-1:0]     mem_addr_o,
  output logic [W-1:0]     mem_wdata_o,
  input  logic [W-1:0]     mem_rdata_i,
  output logic [W-1:0]     sp_o,
  output logic             redirect_o,
  output logic [W-1:0]     redirect_pc_o,
  output logic             wb_valid_o,
  output logic [W-1:0]     wb_data_o,
  output logic             halted_o
);
  op_cls_e      cls;
  logic         use_reg, sp_dec, sp_inc;
  logic [W-1:0] sp_dn;

  scf_decode i_decode (
    .opcode_i (opcode_i),
    .zero_i   (zero_i),
    .cls_o    (cls),
    .use_reg_o(use_reg)
  );

  scf_stack_ptr #(.W(W)) i_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (sp_dec),
    .inc_i  (sp_inc),
    .sp_o   (sp_o),
    .sp_dn_o(sp_dn)
  );

  scf_fsm #(.W(W), .CALL_LEN(CALL_LEN)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue_i),
    .cls_i        (cls),
    .use_reg_i    (use_reg),
    .pc_i         (pc_i),
    .target_i     (target_i),
    .reg_val_i    (reg_val_i),
    .sp_i         (sp_o),
    .sp_dn_i      (sp_dn),
    .mem_rdata_i  (mem_rdata_i),
    .sp_dec_o     (sp_dec),
    .sp_inc_o     (sp_inc),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .wb_valid_o   (wb_valid_o),
    .wb_data_o    (wb_data_o),
    .halted_o     (halted_o)
  );
endmodule

// File: rtl/ctl_stack_seq_chk.sv
module ctl_stack_seq_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         issue_i,
  input logic [7:0]   opcode_i,
  input logic         busy_o,
  input logic         mem_req_o,
  input logic         mem_we_o,
  input logic [W-1:0] mem_addr_o,
  input logic [W-1:0] sp_o,
  input logic         redirect_o,
  input logic         wb_valid_o,
  input logic         halted_o
);
  logic acc;
  assign acc = issue_i && !busy_o && !halted_o;

  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_no_mem_halted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o);

  assert_push_sp_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == 8'h07) |=> (sp_o == W'($past(sp_o) - W'(1))));

  assert_write_at_sp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == sp_o));

  assert_pop_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == 8'h08) |=> busy_o);

  assert_wb_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(busy_o));

  assert_quiet_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!redirect_o && !wb_valid_o && !mem_we_o));

  assert_jump_keeps_sp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (opcode_i == 8'h16 || opcode_i == 8'h25)) |=> $stable(sp_o));
endmodule

bind ctl_stack_seq ctl_stack_seq_chk #(.W(W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .issue_i   (issue_i),
  .opcode_i  (opcode_i),
  .busy_o    (busy_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .sp_o      (sp_o),
  .redirect_o(redirect_o),
  .wb_valid_o(wb_valid_o),
  .halted_o  (halted_o)
);

// File: tb/test_ctl_stack_seq.sv
`timescale 1ns/1ps
module test_ctl_stack_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [7:0] opcode = 8'h01, pc = '0, target = '0, reg_val = '0;
  logic       zero = 1'b0;
  logic       busy, mem_req, mem_we, redirect, wb_valid, halted;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, sp, redirect_pc, wb_data;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_sp;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_stack_seq i_ctl_stack_seq (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .opcode_i(opcode),
    .pc_i(pc), .target_i(target), .reg_val_i(reg_val), .zero_i(zero),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .sp_o(sp), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .wb_valid_o(wb_valid), .wb_data_o(wb_data), .halted_o(halted)
  );

  // synchronous shared memory: read data valid the cycle after the request
  always_ff @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // present for one edge, return at the following negedge
  task automatic present(input logic [7:0] o, input logic [7:0] p, input logic [7:0] t,
                         input logic [7:0] rv, input logic z);
    opcode = o; pc = p; target = t; reg_val = rv; zero = z; issue = 1'b1;
    @(posedge clk);
    @(negedge clk);
    issue = 1'b0; opcode = 8'h01;
  endtask

  task automatic quiet(input string rq);
    chk(rq, "mem_req", {15'd0, mem_req}, 16'd0);
    chk(rq, "redirect", {15'd0, redirect}, 16'd0);
    chk(rq, "wb_valid", {15'd0, wb_valid}, 16'd0);
    chk(rq, "sp", {8'd0, sp}, {8'd0, exp_sp});
    chk(rq, "busy", {15'd0, busy}, 16'd0);
  endtask

  function automatic bit known(input logic [7:0] o);
    return o inside {8'h00, 8'h07, 8'h08, 8'h16, 8'h17, 8'h18, 8'h20, 8'h21, 8'h25, 8'h26};
  endfunction

  task automatic do_push(input logic [7:0] v);
    present(8'h07, 8'h00, 8'h00, v, 1'b0);
    exp_sp = exp_sp - 8'd1;
    exp_mem[exp_sp] = v;
    chk("R2", "push we", {14'd0, mem_req, mem_we}, 16'd3);
    chk("R2", "push addr", {8'd0, mem_addr}, {8'd0, exp_sp});
    chk("R2", "push data", {8'd0, mem_wdata}, {8'd0, v});
    chk("R2", "push sp", {8'd0, sp}, {8'd0, exp_sp});
  endtask

  task automatic do_pop();
    logic [7:0] a;
    a = exp_sp;
    present(8'h08, 8'h00, 8'h00, 8'h00, 1'b0);
    exp_sp = exp_sp + 8'd1;
    chk("R3", "pop read", {14'd0, mem_req, mem_we}, 16'd2);
    chk("R3", "pop addr", {8'd0, mem_addr}, {8'd0, a});
    chk("R3", "pop sp", {8'd0, sp}, {8'd0, exp_sp});
    chk("R3", "pop busy1", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R3", "pop busy2", {15'd0, busy}, 16'd1);
    @(negedge clk);
    chk("R3", "pop wb", {14'd0, wb_valid, busy}, 16'd2);
    chk("R3", "pop data", {8'd0, wb_data}, {8'd0, exp_mem[a]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    exp_sp = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sp", {8'd0, sp}, 16'h00FF);
    chk("R1", "flags", {10'd0, halted, busy, mem_req, mem_we, redirect, wb_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sp after release", {8'd0, sp}, 16'h00FF);

    // R2 / R3: full push sweep wraps SP once, then LIFO pops wrap back
    for (int i = 0; i < 256; i++) do_push(8'(i) ^ 8'h5A);
    chk("R2", "sp after wrap", {8'd0, sp}, 16'h00FF);
    for (int i = 0; i < 256; i++) do_pop();

    // R6 jumps, absolute and register-indirect
    for (int i = 0; i < 256; i++) begin
      logic [7:0] t;
      t = 8'(i * 37 + 11);
      if (i % 2 == 0) present(8'h16, 8'(i), t, ~t, 1'b0);
      else            present(8'h25, 8'(i), ~t, t, 1'b1);
      chk("R6", "jmp redirect", {15'd0, redirect}, 16'd1);
      chk("R6", "jmp target", {8'd0, redirect_pc}, {8'd0, t});
      chk("R6", "jmp no mem", {15'd0, mem_req}, 16'd0);
      chk("R6", "jmp sp", {8'd0, sp}, {8'd0, exp_sp});
    end

    // R7 conditional jumps, all flag combinations
    for (int i = 0; i < 16; i++) begin
      logic [7:0] t;
      logic z, jnz, take;
      t = 8'(i * 53 + 200);
      z = i[0]; jnz = i[1];
      take = jnz ? !z : z;
      present(jnz ? 8'h18 : 8'h17, 8'h40, t, 8'h00, z);
      if (take) begin
        chk("R7", "cond taken", {15'd0, redirect}, 16'd1);
        chk("R7", "cond target", {8'd0, redirect_pc}, {8'd0, t});
      end else begin
        quiet("R7");
      end
    end

    // R4 / R5: call from every address, then return
    for (int i = 0; i < 256; i++) begin
      logic [7:0] t, ra;
      t = 8'(i * 7 + 3);
      ra = 8'(i + 2);
      if (i % 2 == 0) present(8'h20, 8'(i), t, ~t, 1'b0);
      else            present(8'h26, 8'(i), ~t, t, 1'b0);
      exp_sp = exp_sp - 8'd1;
      exp_mem[exp_sp] = ra;
      chk("R4", "call write", {14'd0, mem_req, mem_we}, 16'd3);
      chk("R4", "call addr", {8'd0, mem_addr}, {8'd0, exp_sp});
      chk("R4", "call retaddr", {8'd0, mem_wdata}, {8'd0, ra});
      chk("R4", "call redirect", {7'd0, redirect, redirect_pc}, {8'd1, t});
      present(8'h21, 8'h00, 8'h00, 8'h00, 1'b0);
      exp_sp = exp_sp + 8'd1;
      chk("R5", "ret read", {14'd0, mem_req, mem_we}, 16'd2);
      chk("R5", "ret busy", {15'd0, busy}, 16'd1);
      @(negedge clk);
      @(negedge clk);
      chk("R5", "ret redirect", {6'd0, wb_valid, redirect, redirect_pc}, {8'd1, ra});
      chk("R5", "ret sp", {8'd0, sp}, {8'd0, exp_sp});
    end

    // R9 every unhandled opcode is inert
    for (int o = 0; o < 256; o++) begin
      if (!known(8'(o))) begin
        present(8'(o), 8'(o), 8'hA5, 8'h3C, o[0]);
        quiet("R9");
      end
    end

    // R10 issue while busy is ignored
    do_push(8'hC3);
    present(8'h08, 8'h00, 8'h00, 8'h00, 1'b0);
    exp_sp = exp_sp + 8'd1;
    opcode = 8'h07; reg_val = 8'h99; issue = 1'b1;
    @(negedge clk);
    chk("R10", "no write busy1", {15'd0, mem_we}, 16'd0);
    @(negedge clk);
    issue = 1'b0;
    chk("R10", "no write busy2", {15'd0, mem_we}, 16'd0);
    chk("R10", "pop data", {7'd0, wb_valid, wb_data}, 16'h01C3);
    chk("R10", "sp", {8'd0, sp}, {8'd0, exp_sp});

    // R8 halt is sticky and blocks everything
    present(8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R8", "halted", {15'd0, halted}, 16'd1);
    present(8'h07, 8'h00, 8'h00, 8'h77, 1'b0);
    quiet("R8");
    present(8'h16, 8'h00, 8'h12, 8'h00, 1'b0);
    quiet("R8");
    present(8'h08, 8'h00, 8'h00, 8'h00, 1'b0);
    quiet("R8");
    repeat (4) @(negedge clk);
    chk("R8", "still halted", {15'd0, halted}, 16'd1);
    chk("R8", "no wb", {15'd0, wb_valid}, 16'd0);

    // reset clears halt (R1)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_sp = 8'hFF;
    @(negedge clk);
    chk("R1", "halt cleared", {7'd0, halted, sp}, 16'h00FF);

    finish_run();
  end
endmodule